// File: doc/BRIEF.md
# Per-Row Bank Permutation Address Translator

This block is an address translation stage placed on the path from the internal bus toward the external memory controller of an SDRAM device with four banks. Each incoming address is split into a column field in the low bits, a two-bit bank field above it, and a row field above that. The row field selects one entry of a remapping table. Each entry is a permutation of the four bank numbers. The bank field of the address is replaced by the element of that permutation that the original bank number indexes. All other bits leave the stage exactly as they arrived.

Software-independent table loading uses a one-row write port. The block checks each write before it is stored. An entry that names any bank twice is discarded, and an error strobe is raised. At reset every row holds the identity permutation, so the stage is transparent until a table is loaded. With a permutation chosen per row, sequential streams that would sit in one bank of a row can be spread over several banks. This hides precharge and activate cycles behind other accesses.

Translation goes through one register stage with a valid/ready handshake on both sides. A table write and an accepted address may fall in the same cycle.

Top module: `bank_remap`

## Requirements
- R1: Every output address bit outside the two-bit bank field equals the same bit of the accepted input address (column, row and any bits above the row are unchanged).
- R2: The output bank equals bits [2k+1:2k] of the table entry of the input row, where k is the input bank number.
- R3: After reset every row's entry is 8'hE4, which is the identity permutation {0,1,2,3}, so the output address equals the input address.
- R4: A write with all four 2-bit fields distinct replaces the entry of `wr_row` only, and leaves every other row as it was.
- R5: A write whose fields are not all distinct leaves the table unchanged, and `wr_err` is high for exactly the one cycle after that write's clock edge.
- R6: An address accepted (`in_valid` and `in_ready` high at a clock edge) appears on `out_addr` with `out_valid` high after that edge. While `out_valid` is high and `out_ready` is low, `out_addr` holds and `in_ready` is low.
- R7: When a write and an accepted address for the same row share a clock edge, that address is translated with the old entry, and the next accepted address uses the new entry.
- R8: The field layout is column in bits [COL_W-1:0], bank in bits [COL_W+1:COL_W], and row in bits [COL_W+2+ROW_W-1:COL_W+2].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input address valid |
| in_ready | output | 1 | Stage can accept an address |
| in_addr | input | ADDR_W | Untranslated address |
| out_valid | output | 1 | Translated address valid |
| out_ready | input | 1 | Downstream accepts the translated address |
| out_addr | output | ADDR_W | Address with remapped bank field |
| wr_en | input | 1 | Table write strobe |
| wr_row | input | ROW_W | Row whose entry is written |
| wr_perm | input | 8 | New entry, bank k's target in bits [2k+1:2k] |
| wr_err | output | 1 | Rejected write, one cycle after the write |

## Verification
The two functions that can fall in the same cycle are a table write and the acceptance of an address whose row is the row being written. The bench provokes this by driving both on one clock edge with a new permutation. It expects the resulting output to carry the old mapping, and the following access to the same row to carry the new one. Exhaustive sweeps over every row and bank, made before and after valid and rejected writes, judge that only the addressed row changed.

// File: rtl/bank_remap_pkg.sv
package bank_remap_pkg;
   localparam int BANK_W    = 2;
   localparam int NUM_BANKS = 4;
   localparam int PERM_W    = BANK_W * NUM_BANKS;

   typedef logic [PERM_W-1:0] perm_t;
   typedef logic [BANK_W-1:0] bank_t;

   // identity: bank k maps to k
   localparam perm_t PERM_IDENT = 8'hE4;

   // true when the four fields cover every bank exactly once
   function automatic logic perm_ok(input perm_t p);
      logic [NUM_BANKS-1:0] seen;
      seen = '0;
      for (int k = 0; k < NUM_BANKS; k++) begin
         seen[p[k*BANK_W +: BANK_W]] = 1'b1;
      end
      return &seen;
   endfunction

   function automatic bank_t perm_pick(input perm_t p, input bank_t b);
      return p[b*BANK_W +: BANK_W];
   endfunction
endpackage

// File: rtl/brm_perm_table.sv
module brm_perm_table
   import bank_remap_pkg::*;
#(
   parameter int ROW_W = 6,
   localparam int ROWS = 1 << ROW_W
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [ROW_W-1:0] wr_row,
   input  perm_t            wr_perm,
   output logic             wr_err,
   input  logic [ROW_W-1:0] rd_row,
   output perm_t            rd_perm
);
   perm_t ent_q [ROWS];
   logic  wr_good;

   assign wr_good = perm_ok(wr_perm);

   for (genvar r = 0; r < ROWS; r++) begin : g_row
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            ent_q[r] <= PERM_IDENT;
         end else if (wr_en && wr_good && (wr_row == ROW_W'(r))) begin
            ent_q[r] <= wr_perm;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) wr_err <= 1'b0;
      else        wr_err <= wr_en && !wr_good;
   end

   assign rd_perm = ent_q[rd_row];
endmodule

// File: rtl/brm_xlate.sv
module brm_xlate
   import bank_remap_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int COL_W  = 9,
   parameter int ROW_W  = 6,
   localparam int BANK_LSB = COL_W,
   localparam int ROW_LSB  = COL_W + BANK_W
)(
   input  logic [ADDR_W-1:0] addr_in,
   output logic [ROW_W-1:0]  row,
   input  perm_t             perm,
   output logic [ADDR_W-1:0] addr_out
);
   bank_t bank_in;

   assign row     = addr_in[ROW_LSB +: ROW_W];
   assign bank_in = addr_in[BANK_LSB +: BANK_W];

   always_comb begin
      addr_out = addr_in;
      addr_out[BANK_LSB +: BANK_W] = perm_pick(perm, bank_in);
   end
endmodule

// File: rtl/brm_out_stage.sv
module brm_out_stage #(
   parameter int W = 32
)(
   input  logic         clk,
   input  logic         rst_n,
   input  logic         s_valid,
   output logic         s_ready,
   input  logic [W-1:0] s_data,
   output logic         m_valid,
   input  logic         m_ready,
   output logic [W-1:0] m_data
);
   assign s_ready = !m_valid || m_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         m_valid <= 1'b0;
         m_data  <= '0;
      end else if (s_ready) begin
         m_valid <= s_valid;
         if (s_valid) m_data <= s_data;
      end
   end
endmodule

// File: rtl/bank_remap.sv
module bank_remap
   import bank_remap_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int COL_W  = 9,
   parameter int ROW_W  = 6
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [ADDR_W-1:0] in_addr,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [ADDR_W-1:0] out_addr,
   input  logic              wr_en,
   input  logic [ROW_W-1:0]  wr_row,
   input  logic [7:0]        wr_perm,
   output logic              wr_err
);
   localparam int FIELD_W = COL_W + BANK_W + ROW_W;

   if (FIELD_W > ADDR_W) begin : g_bad_layout
      $error("bank_remap: COL_W+2+ROW_W exceeds ADDR_W");
   end
   if (COL_W < 1 || ROW_W < 1) begin : g_bad_width
      $error("bank_remap: COL_W and ROW_W must be positive");
   end
   if (PERM_W != 8) begin : g_bad_perm
      $error("bank_remap: entry width must be 8");
   end

   logic [ROW_W-1:0]  rd_row;
   perm_t             rd_perm;
   logic [ADDR_W-1:0] xl_addr;

   brm_perm_table #(.ROW_W(ROW_W)) u_table (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_row  (wr_row),
      .wr_perm (wr_perm),
      .wr_err  (wr_err),
      .rd_row  (rd_row),
      .rd_perm (rd_perm)
   );

   brm_xlate #(.ADDR_W(ADDR_W), .COL_W(COL_W), .ROW_W(ROW_W)) u_xlate (
      .addr_in  (in_addr),
      .row      (rd_row),
      .perm     (rd_perm),
      .addr_out (xl_addr)
   );

   brm_out_stage #(.W(ADDR_W)) u_stage (
      .clk     (clk),
      .rst_n   (rst_n),
      .s_valid (in_valid),
      .s_ready (in_ready),
      .s_data  (xl_addr),
      .m_valid (out_valid),
      .m_ready (out_ready),
      .m_data  (out_addr)
   );
endmodule

// File: rtl/bank_remap_chk.sv
module bank_remap_chk #(
   parameter int ADDR_W = 32,
   parameter int COL_W  = 9,
   parameter int ROW_W  = 6
)(
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic              in_ready,
   input logic [ADDR_W-1:0] in_addr,
   input logic              out_valid,
   input logic              out_ready,
   input logic [ADDR_W-1:0] out_addr,
   input logic              wr_en,
   input logic              wr_err
);
   localparam logic [ADDR_W-1:0] KEEP = ~(ADDR_W'(3) << COL_W);

   // R1: non-bank bits of an accepted address reach the output untouched
   p_passthru_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> ((out_addr & KEEP) == ($past(in_addr) & KEEP)));

   // R6: accepted address is presented the next cycle
   p_accept_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> out_valid);

   // R6: stalled output holds its value
   p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_addr)));

   // R5: an error strobe only follows a write
   p_err_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_err |-> $past(wr_en));
endmodule

bind bank_remap bank_remap_chk #(.ADDR_W(ADDR_W), .COL_W(COL_W), .ROW_W(ROW_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_ready  (in_ready),
   .in_addr   (in_addr),
   .out_valid (out_valid),
   .out_ready (out_ready),
   .out_addr  (out_addr),
   .wr_en     (wr_en),
   .wr_err    (wr_err)
);

// File: tb/tb_bank_remap.sv
module tb_bank_remap;
   localparam int CLK_PERIOD = 10;
   localparam int ADDR_W = 10;
   localparam int COL_W  = 3;
   localparam int ROW_W  = 3;
   localparam int ROWS   = 1 << ROW_W;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              in_valid = 1'b0;
   logic              in_ready;
   logic [ADDR_W-1:0] in_addr = '0;
   logic              out_valid;
   logic              out_ready = 1'b1;
   logic [ADDR_W-1:0] out_addr;
   logic              wr_en = 1'b0;
   logic [ROW_W-1:0]  wr_row = '0;
   logic [7:0]        wr_perm = '0;
   logic              wr_err;

   int n_chk = 0;
   int n_bad = 0;
   logic [7:0] mdl [ROWS];

   always #(CLK_PERIOD/2) clk = ~clk;

   bank_remap #(.ADDR_W(ADDR_W), .COL_W(COL_W), .ROW_W(ROW_W)) dut (.*);

   task automatic check(input logic ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [ADDR_W-1:0] mk_addr(input int hi, input int row, input int bank, input int col);
      return ADDR_W'((hi << (COL_W+2+ROW_W)) | (row << (COL_W+2)) | (bank << COL_W) | col);
   endfunction

   function automatic logic [ADDR_W-1:0] expect_of(input logic [ADDR_W-1:0] a);
      logic [ADDR_W-1:0] e;
      int r, b;
      r = int'(a[COL_W+2 +: ROW_W]);
      b = int'(a[COL_W +: 2]);
      e = a;
      e[COL_W +: 2] = mdl[r][2*b +: 2];
      return e;
   endfunction

   // single access with out_ready high; returns captured output
   task automatic xlate(input logic [ADDR_W-1:0] a, output logic [ADDR_W-1:0] o, output logic v);
      @(negedge clk);
      in_valid = 1'b1; in_addr = a;
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      v = out_valid; o = out_addr;
   endtask

   task automatic sweep(input string req);
      logic [ADDR_W-1:0] a, o;
      logic v;
      for (int r = 0; r < ROWS; r++) begin
         for (int b = 0; b < 4; b++) begin
            a = mk_addr((r + b) & 3, r, b, (r*3 + b) & 7);
            xlate(a, o, v);
            check(v && (o == expect_of(a)), req, int'(o), int'(expect_of(a)));
         end
      end
   endtask

   task automatic do_write(input int row, input logic [7:0] p, input logic bad, input string req);
      @(negedge clk);
      wr_en = 1'b1; wr_row = ROW_W'(row); wr_perm = p;
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b0;
      check(wr_err == bad, req, int'(wr_err), int'(bad));
      if (!bad) mdl[row] = p;
      @(posedge clk);
      @(negedge clk);
      check(wr_err == 1'b0, req, int'(wr_err), 0);
   endtask

   function automatic logic [7:0] perm_for(input int r);
      logic [7:0] p;
      int f;
      for (int k = 0; k < 4; k++) begin
         f = (k + r + 1) & 3;
         if (r & 4) f = 3 - f;
         p[2*k +: 2] = 2'(f);
      end
      return p;
   endfunction

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
   end

   initial begin : main
      logic [ADDR_W-1:0] a1, a2, o, first;
      logic v;
      for (int r = 0; r < ROWS; r++) mdl[r] = 8'hE4;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(out_valid == 1'b0 && wr_err == 1'b0, "R3 reset outputs", int'(out_valid), 0);
      rst_n = 1'b1;

      // R3: identity mapping everywhere; R1/R8 field layout
      sweep("R3 identity");

      // R4: distinct permutations per row, then full sweep (R2, R1, R8)
      for (int r = 0; r < ROWS; r++) begin
         do_write(r, perm_for(r), 1'b0, "R4 valid write");
         sweep("R2 remap after write");
      end

      // R5: rejected entries
      do_write(2, 8'b10_01_00_00, 1'b1, "R5 duplicate rejected");
      do_write(5, 8'hFF, 1'b1, "R5 all-same rejected");
      do_write(7, 8'b00_01_10_01, 1'b1, "R5 duplicate rejected");
      sweep("R5 table unchanged");

      // R7: write and access to the same row on one edge
      a1 = mk_addr(1, 3, 2, 5);
      @(negedge clk);
      in_valid = 1'b1; in_addr = a1;
      wr_en = 1'b1; wr_row = 3'd3; wr_perm = 8'h1B;
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0; wr_en = 1'b0;
      check(out_valid && out_addr == expect_of(a1), "R7 old entry used", int'(out_addr), int'(expect_of(a1)));
      mdl[3] = 8'h1B;
      xlate(a1, o, v);
      check(v && o == expect_of(a1), "R7 new entry next access", int'(o), int'(expect_of(a1)));

      // R6: backpressure holds output and blocks input
      a1 = mk_addr(2, 6, 1, 2);
      a2 = mk_addr(0, 1, 3, 7);
      @(negedge clk);
      out_ready = 1'b0; in_valid = 1'b1; in_addr = a1;
      @(posedge clk);
      @(negedge clk);
      first = out_addr;
      check(out_valid && first == expect_of(a1), "R6 latency", int'(first), int'(expect_of(a1)));
      in_addr = a2;
      for (int i = 0; i < 3; i++) begin
         @(posedge clk);
         @(negedge clk);
         check(out_valid && !in_ready && out_addr == first, "R6 hold under stall", int'(out_addr), int'(first));
      end
      out_ready = 1'b1;
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      check(out_valid && out_addr == expect_of(a2), "R6 second accepted", int'(out_addr), int'(expect_of(a2)));
      @(posedge clk);
      @(negedge clk);
      check(!out_valid, "R6 drained", int'(out_valid), 0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
   end
endmodule